// File: doc/BRIEF.md
# Port Access Permission Checker

This block decides whether an instruction that touches I/O ports may proceed. On a request it receives the privilege level of the running code, the privilege level required for port I/O, an enable for a per-port deny bitmap, the bitmap's base address, the first port of the access and the access length. It compares the two privilege levels first. When that comparison passes, the access is granted at once.

When the privilege comparison fails, the bitmap enable decides what happens next. If the bitmap is disabled, the unit reports a protection fault and does not read memory. If the bitmap is enabled, the unit reads one or two bitmap bytes through a simple read port. It faults if any bit for an accessed port is set, and grants otherwise.

The result is a one-cycle `done` pulse with exactly one of `grant` or `fault` set. Address translation and fault delivery are handled outside this block.

Top module: `io_perm_check`

## Requirements
- R1: When a request is accepted with `cur_lvl <= io_lvl` (unsigned), `done` and `grant` are high in the cycle after acceptance, and no bitmap read is made.
- R2: When a request is accepted with `cur_lvl > io_lvl` and `map_en` = 0, `done` and `fault` are high in the cycle after acceptance, and no bitmap read is made.
- R3: The deny bit for port p is bit (p mod 8) of the bitmap byte at address `map_base + (p >> 3)`. A 1 denies that port and a 0 allows it.
- R4: `acc_len` encodes the access length minus one, so 0 means 1 port and 3 means 4 ports. Ports p through p+acc_len are checked. The unit faults if any of their bits is 1 and grants if all are 0.
- R5: When the checked bits lie in one bitmap byte, one read is made and `done` comes 3 cycles after acceptance. When they span two bytes, two reads are made at consecutive addresses, and `done` comes 5 cycles after acceptance. Read data is taken in the cycle after `mem_rd` is asserted.
- R6: `done` lasts one cycle, and exactly one of `grant` or `fault` is high with it. Both are low whenever `done` is low.
- R7: A request is accepted only when `busy` is low. `busy` stays high from acceptance through the `done` cycle. Request pulses and input changes while `busy` is high have no effect on the result in progress.
- R8: During and after reset the unit is idle, with `busy`, `done` and `mem_rd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a check (accepted when not busy) |
| cur_lvl | input | LVL_W | Privilege level of running code |
| io_lvl | input | LVL_W | Privilege level needed for port I/O |
| map_en | input | 1 | Enables the deny bitmap lookup |
| map_base | input | ADDR_W | Byte address of bitmap start |
| port | input | PORT_W | First port of the access |
| acc_len | input | 2 | Access length minus one |
| busy | output | 1 | Check in progress |
| mem_rd | output | 1 | Bitmap read strobe |
| mem_addr | output | ADDR_W | Bitmap byte address |
| mem_data | input | 8 | Bitmap byte, valid the cycle after `mem_rd` |
| done | output | 1 | Result pulse |
| grant | output | 1 | Access allowed (with `done`) |
| fault | output | 1 | Protection fault (with `done`) |

## Verification
The bench builds the block with its default parameters: 16-bit ports, 16-bit bitmap addresses and 2-bit privilege levels. This makes both sides of the privilege comparison reachable, including the equal case. The bench models a 256-byte bitmap at a small base address. With it, the tests place a single set bit either at the edges of a byte or in the second byte of a spanning access, and then check the grant or fault, the read addresses and the latency for each case.

// File: rtl/io_perm_check.sv
module io_perm_check #(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 16,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LVL_W-1:0]  cur_lvl,
  input  logic [LVL_W-1:0]  io_lvl,
  input  logic              map_en,
  input  logic [ADDR_W-1:0] map_base,
  input  logic [PORT_W-1:0] port,
  input  logic [1:0]        acc_len,
  output logic              busy,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  output logic              done,
  output logic              grant,
  output logic              fault
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_EVAL, S_RESP} st_t;

  st_t              st;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       mask_q;
  logic              hi_q;
  logic              deny_q;

  logic        start, priv_ok, spans;
  logic [3:0]  len_mask;
  logic [15:0] wide_mask;
  logic [7:0]  sel_mask;

  assign start     = req_valid && (st == S_IDLE);
  assign priv_ok   = cur_lvl <= io_lvl;
  assign len_mask  = 4'b1111 >> (2'd3 - acc_len);
  assign wide_mask = 16'(len_mask) << port[2:0];
  assign sel_mask  = hi_q ? mask_q[15:8] : mask_q[7:0];
  assign spans     = |mask_q[15:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      mask_q <= '0;
      hi_q   <= 1'b0;
      deny_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          hi_q   <= 1'b0;
          mask_q <= wide_mask;
          addr_q <= map_base + ADDR_W'(port >> 3);
          if (priv_ok) begin
            deny_q <= 1'b0;
            st     <= S_RESP;
          end else if (!map_en) begin
            deny_q <= 1'b1;
            st     <= S_RESP;
          end else begin
            deny_q <= 1'b0;
            st     <= S_READ;
          end
        end
        S_READ: st <= S_EVAL;
        S_EVAL: begin
          deny_q <= deny_q | (|(mem_data & sel_mask));
          if (!hi_q && spans) begin
            hi_q   <= 1'b1;
            addr_q <= addr_q + 1'b1;
            st     <= S_READ;
          end else begin
            st <= S_RESP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = st != S_IDLE;
  assign mem_rd   = st == S_READ;
  assign mem_addr = addr_q;
  assign done     = st == S_RESP;
  assign grant    = done && !deny_q;
  assign fault    = done && deny_q;

  a_r1_priv_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && cur_lvl <= io_lvl) |=> (done && grant && !mem_rd));
  a_r2_disabled_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && cur_lvl > io_lvl && !map_en) |=> (done && fault && !mem_rd));
  a_r6_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (grant ^ fault));
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!grant && !fault));
  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (!mem_rd && busy && !done));
  a_r7_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);

endmodule

// File: tb/io_perm_check_bench.sv
module io_perm_check_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  cur_lvl = '0, io_lvl = '0, acc_len = '0;
  logic        map_en = 1'b0;
  logic [15:0] map_base = '0, port = '0;
  logic        busy, mem_rd, done, grant, fault;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data = '0;
  logic [7:0]  bmap [256];
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  io_perm_check u_io_perm_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_lvl(cur_lvl),
    .io_lvl(io_lvl), .map_en(map_en), .map_base(map_base), .port(port),
    .acc_len(acc_len), .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .done(done), .grant(grant), .fault(fault));

  always @(posedge clk) if (mem_rd) mem_data <= bmap[mem_addr[7:0]];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_map();
    for (int i = 0; i < 256; i++) bmap[i] = 8'h00;
  endtask

  task automatic run(input logic [1:0] c, input logic [1:0] l, input bit en,
                     input logic [15:0] b, input logic [15:0] p, input logic [1:0] len,
                     input bit disturb, input string tag);
    bit exp_fault, any;
    int exp_reads, exp_lat, reads, lat, addr_bad;
    any = 0;
    for (int i = 0; i <= int'(len); i++) begin
      int q = int'(p) + i;
      if (bmap[(int'(b) + (q >> 3)) & 255][q & 7]) any = 1;
    end
    exp_fault = (c > l) && (!en || any);
    exp_reads = (c <= l || !en) ? 0 : ((int'(p[2:0]) + int'(len) + 1 > 8) ? 2 : 1);
    exp_lat   = (exp_reads == 0) ? 1 : (exp_reads == 1 ? 3 : 5);
    @(negedge clk);
    chk(!busy, {tag, " R7 idle before request"}, busy, 0);
    cur_lvl = c; io_lvl = l; map_en = en; map_base = b; port = p; acc_len = len;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    reads = 0; lat = 1; addr_bad = 0;
    while (!done && lat < 20) begin
      if (mem_rd) begin
        if (mem_addr != b + (p >> 3) + 16'(reads)) addr_bad++;
        reads++;
      end
      if (disturb) begin
        req_valid = 1'b1; cur_lvl = 2'd0; io_lvl = 2'd3; port = ~p; acc_len = ~len;
        chk(busy, {tag, " R7 busy during check"}, busy, 1);
      end
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    chk(done && grant == !exp_fault && fault == exp_fault,
        {tag, " R3 R4 result fault"}, fault, exp_fault);
    chk(lat == exp_lat, {tag, " R5 latency"}, lat, exp_lat);
    chk(reads == exp_reads && addr_bad == 0, {tag, " R5 read count"}, reads, exp_reads);
    @(negedge clk);
    chk(!done && !grant && !fault && !busy, {tag, " R6 single pulse"}, done, 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!busy && !done && !mem_rd, "R8 reset idle", {busy, done, mem_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_rd, "R8 after reset", {busy, done, mem_rd}, 0);
  endtask

  task automatic test_privileged();
    clear_map(); bmap[8'h40] = 8'hFF;
    run(2'd0, 2'd3, 1'b1, 16'h0040, 16'h0003, 2'd0, 1'b0, "R1 low level");
    run(2'd2, 2'd2, 1'b1, 16'h0040, 16'h0001, 2'd3, 1'b0, "R1 equal levels");
  endtask

  task automatic test_disabled();
    clear_map();
    run(2'd3, 2'd0, 1'b0, 16'h0040, 16'h0005, 2'd1, 1'b0, "R2 bitmap off");
  endtask

  task automatic test_single_byte();
    clear_map();
    run(2'd3, 2'd1, 1'b1, 16'h0040, 16'h0010, 2'd3, 1'b0, "R4 clear grant");
    bmap[8'h42] = 8'h80;
    run(2'd3, 2'd1, 1'b1, 16'h0040, 16'h0017, 2'd0, 1'b0, "R3 bit7 deny");
    run(2'd3, 2'd1, 1'b1, 16'h0040, 16'h0014, 2'd2, 1'b0, "R4 neighbour allowed");
    bmap[8'h42] = 8'h01;
    run(2'd3, 2'd1, 1'b1, 16'h0040, 16'h0010, 2'd3, 1'b0, "R3 bit0 deny");
  endtask

  task automatic test_span();
    clear_map();
    run(2'd1, 2'd0, 1'b1, 16'h0040, 16'h0036, 2'd3, 1'b0, "R5 span grant");
    bmap[8'h47] = 8'h02;
    run(2'd1, 2'd0, 1'b1, 16'h0040, 16'h0036, 2'd3, 1'b0, "R5 span deny second");
    run(2'd1, 2'd0, 1'b1, 16'h0040, 16'h0037, 2'd1, 1'b0, "R5 span grant edge");
  endtask

  task automatic test_busy_ignored();
    clear_map(); bmap[8'h50] = 8'h04;
    run(2'd3, 2'd0, 1'b1, 16'h0040, 16'h0082, 2'd0, 1'b1, "R7 disturbed deny");
    clear_map();
    run(2'd3, 2'd0, 1'b1, 16'h0040, 16'h0086, 2'd3, 1'b1, "R7 disturbed span");
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_privileged();
        test_disabled();
        test_single_byte();
        test_span();
        test_busy_ignored();
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule